// File: doc/BRIEF.md
# Software-Generated Interrupt Request Router

This block receives a 64-bit inter-processor interrupt request written by one of several CPUs in a single cluster. It splits the request word into its fields and works out which CPUs should receive the interrupt. It then records the interrupt for each of them. A request may name its targets through a bitmap. It may instead ask for delivery to every CPU other than the writer, and in that case the bitmap plays no part.

A target that is the writer itself is handed straight to a local output, one cycle after the request. Every other target gets a bit set in its own 16-bit pending vector, one bit per interrupt ID. Each CPU drains its pending vector through a valid/ready port that always offers the lowest pending ID. A request that names a higher affinity level or a non-zero range is not delivered. It only increments a saturating drop counter.

Top module: `sgi_router`

## Requirements
- R1: The interrupt ID is taken from request bits [27:24] and is the ID delivered on the self output and set in the pending vectors.
- R2: When bit 40 is 0, request bit N (bits [15:0]) selects CPU N. Bits at positions NUM_CPU and above have no effect.
- R3: When bit 40 is 1, every CPU except the writer (`req_src`) is targeted, whatever bits [15:0] hold. The self output stays low.
- R4: When bit 40 is 0 and the writer's own bitmap bit is set, the cycle after the request shows `self_valid`=1, `self_cpu`=writer and `self_id`=ID. The writer's pending vector is not changed.
- R5: Every targeted CPU other than the writer has its pending bit for the ID set at the request's clock edge. This bit is visible on its drain port in the following cycle.
- R6: A request with any of bits [23:16], [39:32], [55:48] or [47:44] non-zero is dropped. No self delivery happens and no pending bit changes. `drop_count` increases by one and saturates at 2^CNT_W-1.
- R7: Each drain port shows valid=1 and the lowest pending ID while its vector is non-zero. A cycle with valid and ready both high clears that ID.
- R8: A set and a drain clear that arrive in the same cycle both take effect when they hit different bits. When they hit the same bit, the bit stays set.
- R9: After reset, all pending vectors are empty, `self_valid` is 0 and `drop_count` is 0.
- R10: While `req_valid` is 0 the request word has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request word is present this cycle |
| req_src | input | CPU_W | Index of the writing CPU |
| req_word | input | 64 | Request word |
| self_valid | output | 1 | Writer targeted itself (one-cycle pulse) |
| self_cpu | output | CPU_W | Writer index for the self delivery |
| self_id | output | 4 | Interrupt ID for the self delivery |
| drain_valid | output | NUM_CPU | Per-CPU: some ID pending |
| drain_id | output | NUM_CPU*4 | Per-CPU lowest pending ID, CPU c at bits [4c+3:4c] |
| drain_ready | input | NUM_CPU | Per-CPU acknowledge of the offered ID |
| drop_count | output | CNT_W | Saturating count of dropped requests |

## Verification
The bench builds the router with four CPUs and a 3-bit drop counter. With that narrow counter, nine dropped requests run past saturation. With four CPUs, every writer can be combined with every low bitmap value and both broadcast settings, so all 128 pairs are swept with noisy upper bitmap bits. After each group of requests every pending vector is drained and compared in ascending order against a model. Same-cycle set and clear is driven directly, both on distinct bits and on a shared bit.

// File: rtl/sgi_pkg.sv
package sgi_pkg;

    localparam int WORD_W = 64;
    localparam int ID_W   = 4;
    localparam int NUM_ID = 1 << ID_W;
    localparam int MAP_W  = 16;

    typedef struct packed {
        logic [MAP_W-1:0] tmap;
        logic [7:0]       lvl1;
        logic [ID_W-1:0]  id;
        logic [7:0]       lvl2;
        logic             all_but_self;
        logic [3:0]       range_sel;
        logic [7:0]       lvl3;
    } req_fields_t;

    function automatic req_fields_t split_req(input logic [WORD_W-1:0] w);
        req_fields_t f;
        f.tmap         = w[15:0];
        f.lvl1         = w[23:16];
        f.id           = w[27:24];
        f.lvl2         = w[39:32];
        f.all_but_self = w[40];
        f.range_sel    = w[47:44];
        f.lvl3         = w[55:48];
        return f;
    endfunction

endpackage

// File: rtl/sgi_decode.sv
module sgi_decode
    import sgi_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int CPU_W   = 2
) (
    input  logic                  valid_i,
    input  logic [CPU_W-1:0]      src_i,
    input  logic [WORD_W-1:0]     word_i,
    output logic                  drop_o,
    output logic                  self_o,
    output logic [ID_W-1:0]       id_o,
    output logic [NUM_CPU-1:0]    remote_o
);

    req_fields_t f;
    logic        in_cluster;
    logic        unused_word;

    assign f           = split_req(word_i);
    assign unused_word = ^word_i;
    assign in_cluster  = (f.lvl1 == '0) && (f.lvl2 == '0) &&
                         (f.lvl3 == '0) && (f.range_sel == '0);

    assign drop_o = valid_i && !in_cluster;
    assign id_o   = f.id;
    assign self_o = valid_i && in_cluster && !f.all_but_self && f.tmap[src_i];

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_tgt
        logic picked;
        logic is_src;
        assign is_src      = (CPU_W'(c) == src_i);
        assign picked      = f.all_but_self ? 1'b1 : f.tmap[c];
        assign remote_o[c] = valid_i && in_cluster && picked && !is_src;
    end

endmodule

// File: rtl/sgi_pend_bank.sv
module sgi_pend_bank #(
    parameter int NUM_ID = 16,
    parameter int ID_W   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_i,
    input  logic [ID_W-1:0] set_id_i,
    output logic            valid_o,
    output logic [ID_W-1:0] id_o,
    input  logic            ready_i
);

    typedef struct packed {
        logic [NUM_ID-1:0] pend;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        id_o = '0;
        for (int i = NUM_ID - 1; i >= 0; i--) begin
            if (st_q.pend[i]) id_o = ID_W'(i);
        end
    end

    assign valid_o = |st_q.pend;

    always_comb begin
        st_d = st_q;
        if (valid_o && ready_i) st_d.pend[id_o] = 1'b0;
        if (set_i)              st_d.pend[set_id_i] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> st_q.pend[$past(set_id_i)]);

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i && !(set_i && set_id_i == id_o)) |=> !st_q.pend[$past(id_o)]);

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !(valid_o && ready_i)) |=> $stable(st_q.pend));

endmodule

// File: rtl/sgi_router.sv
module sgi_router
    import sgi_pkg::*;
#(
    parameter int  NUM_CPU = 4,
    parameter int  CNT_W   = 8,
    localparam int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [CPU_W-1:0]        req_src,
    input  logic [63:0]             req_word,
    output logic                    self_valid,
    output logic [CPU_W-1:0]        self_cpu,
    output logic [3:0]              self_id,
    output logic [NUM_CPU-1:0]      drain_valid,
    output logic [NUM_CPU*4-1:0]    drain_id,
    input  logic [NUM_CPU-1:0]      drain_ready,
    output logic [CNT_W-1:0]        drop_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             sv;
        logic [CPU_W-1:0] scpu;
        logic [ID_W-1:0]  sid;
        logic [CNT_W-1:0] drops;
    } top_t;

    top_t st_d, st_q;

    logic               dec_drop;
    logic               dec_self;
    logic [ID_W-1:0]    dec_id;
    logic [NUM_CPU-1:0] dec_remote;

    sgi_decode #(.NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_dec (
        .valid_i  (req_valid),
        .src_i    (req_src),
        .word_i   (req_word),
        .drop_o   (dec_drop),
        .self_o   (dec_self),
        .id_o     (dec_id),
        .remote_o (dec_remote)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
        sgi_pend_bank #(.NUM_ID(NUM_ID), .ID_W(ID_W)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (dec_remote[c]),
            .set_id_i (dec_id),
            .valid_o  (drain_valid[c]),
            .id_o     (drain_id[c*ID_W +: ID_W]),
            .ready_i  (drain_ready[c])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.sv   = dec_self;
        if (dec_self) begin
            st_d.scpu = req_src;
            st_d.sid  = dec_id;
        end
        if (dec_drop && st_q.drops != CNT_MAX) st_d.drops = st_q.drops + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign self_valid = st_q.sv;
    assign self_cpu   = st_q.scpu;
    assign self_id    = st_q.sid;
    assign drop_count = st_q.drops;

    p_bcast_no_self_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_word[40]) |=> !self_valid);

    p_drop_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dec_drop |=> !self_valid);

    p_drop_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_drop && drop_count != CNT_MAX) |=> drop_count == $past(drop_count) + 1'b1);

    p_no_req_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!self_valid && $stable(drop_count)));

endmodule

// File: tb/sim_sgi_router.sv
module sim_sgi_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_src = '0;
    logic [63:0] req_word = '0;
    logic        self_valid;
    logic [1:0]  self_cpu;
    logic [3:0]  self_id;
    logic [3:0]  drain_valid;
    logic [15:0] drain_id;
    logic [3:0]  drain_ready = '0;
    logic [2:0]  drop_count;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [15:0] exp_pend [4];

    always #5 clk = ~clk;

    sgi_router #(.NUM_CPU(4), .CNT_W(3)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_src(req_src),
        .req_word(req_word), .self_valid(self_valid), .self_cpu(self_cpu),
        .self_id(self_id), .drain_valid(drain_valid), .drain_id(drain_id),
        .drain_ready(drain_ready), .drop_count(drop_count)
    );

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", r, act, exp);
        end
    endtask

    function automatic logic [63:0] mkw(input logic [15:0] tm, input logic [3:0] id,
                                        input logic bc, input logic [7:0] a1,
                                        input logic [7:0] a2, input logic [7:0] a3,
                                        input logic [3:0] rs);
        logic [63:0] w = '0;
        w[15:0] = tm; w[23:16] = a1; w[27:24] = id; w[39:32] = a2;
        w[40] = bc; w[47:44] = rs; w[55:48] = a3;
        w[31:28] = 4'hF; w[63:56] = 8'h5A;
        return w;
    endfunction

    task automatic send(input logic [1:0] src, input logic [63:0] w);
        @(negedge clk);
        req_valid = 1'b1; req_src = src; req_word = w;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic void model(input logic [1:0] src, input logic [63:0] w);
        for (int t = 0; t < 4; t++) begin
            logic sel = w[40] ? 1'b1 : w[t];
            if (sel && t != int'(src)) exp_pend[t][w[27:24]] = 1'b1;
        end
    endfunction

    task automatic drain_all();
        for (int c = 0; c < 4; c++) begin
            while (exp_pend[c] != 0) begin
                int lo = 0;
                for (int i = 15; i >= 0; i--) if (exp_pend[c][i]) lo = i;
                chk("R7 drain valid", 32'(drain_valid[c]), 1);
                chk("R7 lowest id", 32'(drain_id[c*4 +: 4]), 32'(lo));
                drain_ready[c] = 1'b1;
                @(negedge clk);
                drain_ready[c] = 1'b0;
                exp_pend[c][lo] = 1'b0;
            end
            chk("R7 drained empty", 32'(drain_valid[c]), 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 4; c++) exp_pend[c] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 self_valid", 32'(self_valid), 0);
        chk("R9 drain_valid", 32'(drain_valid), 0);
        chk("R9 drop_count", 32'(drop_count), 0);

        // R10: word present without valid
        req_word = mkw(16'hFFFF, 4'd3, 1'b0, 0, 0, 0, 0);
        req_src = 2'd1;
        @(negedge clk); @(negedge clk);
        chk("R10 no self", 32'(self_valid), 0);
        chk("R10 no pending", 32'(drain_valid), 0);
        chk("R10 no drop", 32'(drop_count), 0);

        // R1..R5 sweep: writer x broadcast x bitmap, noisy upper bitmap bits
        for (int s = 0; s < 4; s++) begin
            for (int bc = 0; bc < 2; bc++) begin
                for (int bm = 0; bm < 16; bm++) begin
                    logic [15:0] tm = {4'(bm * 7 + s), 8'hC3 ^ 8'(bm), 4'(bm)};
                    logic [3:0]  id = 4'((s * 5 + bm + bc * 3) % 16);
                    logic [63:0] w  = mkw(tm, id, bc[0], 0, 0, 0, 0);
                    logic        es = (bc == 0) && tm[s];
                    send(2'(s), w);
                    model(2'(s), w);
                    chk(bc ? "R3 no self on broadcast" : "R4 self pulse", 32'(self_valid), 32'(es));
                    if (es) begin
                        chk("R4 self cpu", 32'(self_cpu), 32'(s));
                        chk("R1 self id", 32'(self_id), 32'(id));
                    end
                    for (int c = 0; c < 4; c++)
                        chk("R5 R2 pending present", 32'(drain_valid[c]), 32'(exp_pend[c] != 0));
                    if (bm % 4 == 3) drain_all();
                end
            end
        end

        // R7: ordering of several pending IDs
        send(2'd0, mkw(16'h0002, 4'd13, 0, 0, 0, 0, 0)); model(2'd0, mkw(16'h0002, 4'd13, 0, 0, 0, 0, 0));
        send(2'd0, mkw(16'h0002, 4'd2, 0, 0, 0, 0, 0));  model(2'd0, mkw(16'h0002, 4'd2, 0, 0, 0, 0, 0));
        send(2'd3, mkw(16'h0002, 4'd7, 0, 0, 0, 0, 0));  model(2'd3, mkw(16'h0002, 4'd7, 0, 0, 0, 0, 0));
        chk("R7 head is lowest", 32'(drain_id[7:4]), 2);
        drain_all();

        // R8: set and clear on different bits in the same cycle
        send(2'd0, mkw(16'h0002, 4'd5, 0, 0, 0, 0, 0));
        send(2'd0, mkw(16'h0002, 4'd2, 0, 0, 0, 0, 0));
        @(negedge clk);
        drain_ready[1] = 1'b1; req_valid = 1'b1; req_src = 2'd0;
        req_word = mkw(16'h0002, 4'd9, 0, 0, 0, 0, 0);
        @(negedge clk);
        drain_ready[1] = 1'b0; req_valid = 1'b0;
        chk("R8 different bits head", 32'(drain_id[7:4]), 5);
        exp_pend[1] = 16'h0220;
        drain_all();

        // R8: set and clear on the same bit
        send(2'd2, mkw(16'h0002, 4'd3, 0, 0, 0, 0, 0));
        @(negedge clk);
        drain_ready[1] = 1'b1; req_valid = 1'b1; req_src = 2'd2;
        req_word = mkw(16'h0002, 4'd3, 0, 0, 0, 0, 0);
        @(negedge clk);
        drain_ready[1] = 1'b0; req_valid = 1'b0;
        chk("R8 same bit set wins", 32'(drain_valid[1]), 1);
        exp_pend[1] = 16'h0008;
        drain_all();

        // R6: dropped requests, counter saturates at 7
        for (int k = 0; k < 9; k++) begin
            logic [63:0] w;
            case (k % 4)
                0: w = mkw(16'hFFFF, 4'd1, 0, 8'h01, 0, 0, 0);
                1: w = mkw(16'hFFFF, 4'd1, 1, 0, 8'h80, 0, 0);
                2: w = mkw(16'hFFFF, 4'd1, 0, 0, 0, 8'h10, 0);
                default: w = mkw(16'hFFFF, 4'd1, 1, 0, 0, 0, 4'h4);
            endcase
            send(2'(k % 4), w);
            chk("R6 no self", 32'(self_valid), 0);
            chk("R6 no pending", 32'(drain_valid), 0);
            chk("R6 drop count", 32'(drop_count), 32'((k + 1 > 7) ? 7 : k + 1));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule